// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

This block sits between the load/store stage of a processor and a byte-addressable data memory that is 32 bits wide. Each cycle it can take one access request. The request carries a byte address, a size code (byte, halfword or word), a direction (store or load) and a flag that selects zero-extension for loads. For a store it drives the word address to memory, together with a 4-bit lane write mask and the store data placed on the lanes. For a load it records where the item sits in the word and how to extend it. In the next cycle it takes the word that memory returns, picks out the item and right-justifies it.

Lanes are numbered in big-endian order. Byte offset 0 inside a word is the most significant lane (bits 31:24) and offset 3 is the least significant lane (bits 7:0). Consecutive words are 4 byte addresses apart, so word k from a base address is at base + 4*k. An access whose address does not fit its size raises a misaligned flag in the same cycle. Such an access never writes memory and never produces load data.

Top module: `lsa_top`

## Requirements
- R1: `mem_addr` always equals `req_addr` with its two lowest bits forced to zero.
- R2: Size codes are 0 = byte, 1 = halfword, 2 = word, and 3 is reserved. An aligned byte store at offset o (the value of `req_addr[1:0]`) asserts only bit 3-o of `mem_wstrb`. Bit 3 is the lane at bits 31:24.
- R3: An aligned halfword store asserts `mem_wstrb` = 4'b1100 at offset 0 and 4'b0011 at offset 2. An aligned word store asserts 4'b1111.
- R4: On a store, `mem_wdata` carries `req_wdata[7:0]` on all four lanes for a byte. For a halfword it carries `req_wdata[15:0]` in both halves. For a word it carries `req_wdata` unchanged.
- R5: `misaligned` is high exactly when `req_valid` is high and one of these holds: the size is halfword and the address is odd, the size is word and `req_addr[1:0]` is not zero, or the size code is 3.
- R6: `mem_wstrb` is all zero whenever no store is requested, the request is a load, or the request is misaligned.
- R7: An aligned load accepted in cycle N makes `load_valid` high in cycle N+1, using the `mem_rdata` present in cycle N+1. In every other case `load_valid` is low in the next cycle and `load_data` is zero.
- R8: A byte load returns `mem_rdata` bits [31-8o:24-8o] for offset o. The result is sign-extended to 32 bits, or zero-extended when `req_unsigned` was high.
- R9: A halfword load returns `mem_rdata[31:16]` at offset 0 and `mem_rdata[15:0]` at offset 2. It is extended as in R8.
- R10: A word load returns `mem_rdata` unchanged.
- R11: While `rst` is high and in the first cycle after it falls, `load_valid` is low and `load_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_unsigned | input | 1 | Load extension: 1 = zero, 0 = sign |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data, right-justified |
| mem_rdata | input | 32 | Word returned by memory one cycle after a load |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wstrb | output | 4 | Per-lane write enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Store data placed on the lanes |
| misaligned | output | 1 | Current request violates alignment |
| load_valid | output | 1 | `load_data` holds a load result |
| load_data | output | 32 | Extracted and extended load result |

## Verification
Most of the block is a direct mapping from the request to the memory outputs, so an error in lane steering or strobe decoding shows up at the ports in the same cycle as the request. The only state is the captured load context. If it holds a wrong offset, size or extension flag, the next cycle's `load_data` picks the wrong lane or fills the upper bits wrongly. If it holds a wrong valid bit, `load_valid` is wrong one cycle after the request. Random traffic that mixes loads, stores and misaligned requests back to back shows each of these faults within one cycle of the request that triggers it.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    localparam int WORD_W     = 32;
    localparam int LANE_W     = 8;
    localparam int WORD_BYTES = WORD_W / LANE_W;
    localparam int OFS_W      = $clog2(WORD_BYTES);
    localparam int HALF_W     = 2 * LANE_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    // Context kept from a load request until its data returns
    typedef struct packed {
        logic              valid;
        acc_size_e         size;
        logic [OFS_W-1:0]  ofs;
        logic              zext;
    } load_ctx_t;

    function automatic logic [WORD_W-1:0] ext_byte(input logic [LANE_W-1:0] b, input logic zext);
        logic fill;
        fill = ~zext & b[LANE_W-1];
        return {{(WORD_W-LANE_W){fill}}, b};
    endfunction

    function automatic logic [WORD_W-1:0] ext_half(input logic [HALF_W-1:0] h, input logic zext);
        logic fill;
        fill = ~zext & h[HALF_W-1];
        return {{(WORD_W-HALF_W){fill}}, h};
    endfunction

endpackage

// File: rtl/lsa_align_check.sv
module lsa_align_check
    import lsa_pkg::*;
(
    input  acc_size_e         size,
    input  logic [OFS_W-1:0]  ofs,
    output logic              bad
);
    always_comb begin
        unique case (size)
            SZ_BYTE: bad = 1'b0;
            SZ_HALF: bad = ofs[0];
            SZ_WORD: bad = |ofs;
            default: bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/lsa_store_steer.sv
module lsa_store_steer
    import lsa_pkg::*;
(
    input  acc_size_e            size,
    input  logic [OFS_W-1:0]     ofs,
    input  logic [WORD_W-1:0]    wdata,
    output logic [WORD_W-1:0]    lanes,
    output logic [WORD_BYTES-1:0] strb
);
    // lane i holds bits 8i+7:8i; its big-endian byte offset is WORD_BYTES-1-i
    for (genvar i = 0; i < WORD_BYTES; i++) begin : g_lane
        localparam logic [OFS_W-1:0] LANE_OFS = OFS_W'(WORD_BYTES - 1 - i);
        localparam bit UPPER_HALF = (i >= WORD_BYTES / 2);

        always_comb begin
            unique case (size)
                SZ_BYTE: begin
                    lanes[i*LANE_W +: LANE_W] = wdata[LANE_W-1:0];
                    strb[i] = (ofs == LANE_OFS);
                end
                SZ_HALF: begin
                    lanes[i*LANE_W +: LANE_W] = wdata[(i % 2)*LANE_W +: LANE_W];
                    strb[i] = (ofs[OFS_W-1] != UPPER_HALF);
                end
                SZ_WORD: begin
                    lanes[i*LANE_W +: LANE_W] = wdata[i*LANE_W +: LANE_W];
                    strb[i] = 1'b1;
                end
                default: begin
                    lanes[i*LANE_W +: LANE_W] = wdata[i*LANE_W +: LANE_W];
                    strb[i] = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
    import lsa_pkg::*;
(
    input  load_ctx_t          ctx,
    input  logic [WORD_W-1:0]  rdata,
    output logic [WORD_W-1:0]  result
);
    logic [LANE_W-1:0] sel_byte;
    logic [HALF_W-1:0] sel_half;

    // big-endian: offset o sits at lane (3 - o), i.e. start bit 8*(~o)
    assign sel_byte = rdata[{~ctx.ofs, 3'b000} +: LANE_W];
    assign sel_half = ctx.ofs[OFS_W-1] ? rdata[HALF_W-1:0] : rdata[WORD_W-1:HALF_W];

    always_comb begin
        if (!ctx.valid) begin
            result = '0;
        end else begin
            unique case (ctx.size)
                SZ_BYTE: result = ext_byte(sel_byte, ctx.zext);
                SZ_HALF: result = ext_half(sel_half, ctx.zext);
                default: result = rdata;
            endcase
        end
    end
endmodule

// File: rtl/lsa_top.sv
module lsa_top
    import lsa_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  req_store,
    input  logic [1:0]            req_size,
    input  logic                  req_unsigned,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [WORD_W-1:0]     req_wdata,
    input  logic [WORD_W-1:0]     mem_rdata,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [WORD_BYTES-1:0] mem_wstrb,
    output logic [WORD_W-1:0]     mem_wdata,
    output logic                  misaligned,
    output logic                  load_valid,
    output logic [WORD_W-1:0]     load_data
);
    acc_size_e               size;
    logic [OFS_W-1:0]        ofs;
    logic                    addr_bad;
    logic [WORD_BYTES-1:0]   raw_strb;
    load_ctx_t               ctx_q;

    assign size = acc_size_e'(req_size);
    assign ofs  = req_addr[OFS_W-1:0];

    lsa_align_check u_align (
        .size (size),
        .ofs  (ofs),
        .bad  (addr_bad)
    );

    lsa_store_steer u_steer (
        .size  (size),
        .ofs   (ofs),
        .wdata (req_wdata),
        .lanes (mem_wdata),
        .strb  (raw_strb)
    );

    assign mem_addr   = {req_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
    assign misaligned = req_valid & addr_bad;
    assign mem_wstrb  = (req_valid & req_store & ~addr_bad) ? raw_strb : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '0;
        end else begin
            ctx_q.valid <= req_valid & ~req_store & ~addr_bad;
            ctx_q.size  <= size;
            ctx_q.ofs   <= ofs;
            ctx_q.zext  <= req_unsigned;
        end
    end

    lsa_load_extract u_extract (
        .ctx    (ctx_q),
        .rdata  (mem_rdata),
        .result (load_data)
    );

    assign load_valid = ctx_q.valid;

endmodule

// File: rtl/lsa_checker.sv
module lsa_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_store,
    input logic [1:0]        req_size,
    input logic [ADDR_W-1:0] req_addr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [3:0]        mem_wstrb,
    input logic              misaligned,
    input logic              load_valid,
    input logic [31:0]       load_data
);
    logic wr_ok;
    assign wr_ok = req_valid && req_store && !misaligned;

    assert_aligned_addr_R1: assert property (@(posedge clk) disable iff (rst)
        mem_addr[1:0] == 2'b00 && mem_addr[ADDR_W-1:2] == req_addr[ADDR_W-1:2]);

    assert_byte_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && req_size == 2'd0) |-> $countones(mem_wstrb) == 1);

    assert_half_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && req_size == 2'd1) |-> (mem_wstrb == 4'b1100 || mem_wstrb == 4'b0011));

    assert_word_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && req_size == 2'd2) |-> mem_wstrb == 4'b1111);

    assert_flag_needs_req_R5: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !misaligned);

    assert_no_write_R6: assert property (@(posedge clk) disable iff (rst)
        !wr_ok |-> mem_wstrb == 4'b0000);

    assert_load_follows_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_store && !misaligned) |=> load_valid);

    assert_load_absent_R7: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_store && !misaligned) |=> !load_valid);

    assert_idle_data_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !load_valid |-> load_data == 32'd0);

    assert_reset_clears_R11: assert property (@(posedge clk)
        rst |=> !load_valid);

endmodule

bind lsa_top lsa_checker #(.ADDR_W(ADDR_W)) u_lsa_checker (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_store  (req_store),
    .req_size   (req_size),
    .req_addr   (req_addr),
    .mem_addr   (mem_addr),
    .mem_wstrb  (mem_wstrb),
    .misaligned (misaligned),
    .load_valid (load_valid),
    .load_data  (load_data)
);

// File: tb/tb_lsa_top.sv
`timescale 1ns/1ps
module tb_lsa_top;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_store = 1'b0;
    logic [1:0]        req_size = 2'd0;
    logic              req_unsigned = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic [31:0]       mem_rdata = '0;
    logic [ADDR_W-1:0] mem_addr;
    logic [3:0]        mem_wstrb;
    logic [31:0]       mem_wdata;
    logic              misaligned;
    logic              load_valid;
    logic [31:0]       load_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // model of the pending load
    bit       pv = 1'b0;
    bit [1:0] psz = 2'd0;
    bit [1:0] pofs = 2'd0;
    bit       pzx = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    lsa_top #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_unsigned(req_unsigned), .req_addr(req_addr),
        .req_wdata(req_wdata), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wstrb(mem_wstrb), .mem_wdata(mem_wdata), .misaligned(misaligned),
        .load_valid(load_valid), .load_data(load_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit exp_bad(input bit [1:0] sz, input bit [1:0] o);
        case (sz)
            2'd0: return 1'b0;
            2'd1: return o[0];
            2'd2: return o != 2'd0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic bit [3:0] exp_strb(input bit [1:0] sz, input bit [1:0] o);
        case (sz)
            2'd0: return 4'b1000 >> o;
            2'd1: return (o == 2'd0) ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic bit [31:0] exp_wdata(input bit [1:0] sz, input bit [31:0] d);
        case (sz)
            2'd0: return {4{d[7:0]}};
            2'd1: return {2{d[15:0]}};
            default: return d;
        endcase
    endfunction

    function automatic bit [31:0] exp_load(input bit [1:0] sz, input bit [1:0] o,
                                           input bit zx, input bit [31:0] rd);
        bit [31:0] sh;
        sh = rd << (8 * o);
        case (sz)
            2'd0: return zx ? {24'd0, sh[31:24]} : {{24{sh[31]}}, sh[31:24]};
            2'd1: return zx ? {16'd0, sh[31:16]} : {{16{sh[31]}}, sh[31:16]};
            default: return rd;
        endcase
    endfunction

    // drive one request plus the memory word for the previous one, then check
    task automatic apply(input bit v, input bit st, input bit [1:0] sz, input bit uns,
                         input bit [31:0] addr, input bit [31:0] wd, input bit [31:0] rd);
        bit bad;
        @(negedge clk);
        req_valid = v; req_store = st; req_size = sz; req_unsigned = uns;
        req_addr = addr; req_wdata = wd; mem_rdata = rd;
        #1;
        bad = exp_bad(sz, addr[1:0]);
        check("R1 mem_addr", mem_addr, {addr[31:2], 2'b00});
        check("R5 misaligned", {31'd0, misaligned}, {31'd0, v & bad});
        if (v && st && !bad) begin
            if (sz == 2'd0) check("R2 byte strobe", {28'd0, mem_wstrb}, {28'd0, exp_strb(sz, addr[1:0])});
            else check("R3 half/word strobe", {28'd0, mem_wstrb}, {28'd0, exp_strb(sz, addr[1:0])});
        end else begin
            check("R6 strobe off", {28'd0, mem_wstrb}, 32'd0);
        end
        if (st && sz != 2'd3)
            check("R4 lane data", mem_wdata, exp_wdata(sz, wd));
        check("R7 load_valid", {31'd0, load_valid}, {31'd0, pv});
        if (!pv) check("R7 idle data", load_data, 32'd0);
        else if (psz == 2'd0) check("R8 byte load", load_data, exp_load(psz, pofs, pzx, rd));
        else if (psz == 2'd1) check("R9 half load", load_data, exp_load(psz, pofs, pzx, rd));
        else check("R10 word load", load_data, exp_load(psz, pofs, pzx, rd));
        pv = v && !st && !bad; psz = sz; pofs = addr[1:0]; pzx = uns;
    endtask

    initial begin
        #(8ns * 150000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        bit [31:0] r;
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        #1;
        check("R11 reset load_valid", {31'd0, load_valid}, 32'd0);
        check("R11 reset load_data", load_data, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R11 after reset", {31'd0, load_valid}, 32'd0);

        // directed stores: bytes at each offset, halves, word
        for (int o = 0; o < 4; o++) apply(1, 1, 2'd0, 0, 32'h1000 + o, 32'h1234_56A5, 0);
        apply(1, 1, 2'd1, 0, 32'h2000, 32'hDEAD_BEEF, 0);
        apply(1, 1, 2'd1, 0, 32'h2002, 32'hDEAD_BEEF, 0);
        apply(1, 1, 2'd2, 0, 32'h2004, 32'hCAFE_F00D, 0);
        // misaligned stores
        apply(1, 1, 2'd1, 0, 32'h2001, 32'h1111_2222, 0);
        apply(1, 1, 2'd2, 0, 32'h2006, 32'h3333_4444, 0);
        apply(1, 1, 2'd3, 0, 32'h2008, 32'h5555_6666, 0);
        // idle store request (valid low)
        apply(0, 1, 2'd2, 0, 32'h2010, 32'h7777_8888, 0);
        // directed loads: every byte offset signed and unsigned
        for (int o = 0; o < 4; o++) begin
            apply(1, 0, 2'd0, 0, 32'h3000 + o, 0, 32'h80FF_7F01);
            apply(1, 0, 2'd0, 1, 32'h3000 + o, 0, 32'h80FF_7F01);
        end
        apply(1, 0, 2'd1, 0, 32'h3000, 0, 32'h80FF_7F01);
        apply(1, 0, 2'd1, 1, 32'h3002, 0, 32'h80FF_7F01);
        apply(1, 0, 2'd1, 0, 32'h3002, 0, 32'h80FF_7F01);
        apply(1, 0, 2'd2, 0, 32'h3004, 0, 32'h80FF_9F01);
        // misaligned load followed by a check that nothing returns
        apply(1, 0, 2'd2, 0, 32'h3005, 0, 32'h1357_9BDF);
        apply(0, 0, 2'd0, 0, 32'h0, 0, 32'h2468_ACE0);
        apply(0, 0, 2'd0, 0, 32'h0, 0, 32'hFFFF_FFFF);

        // constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            r = $urandom;
            apply(r[0] | r[1], r[2], (r[7:4] == 4'hF) ? 2'd3 : 2'(r[9:8] % 3),
                  r[3], $urandom, $urandom, $urandom);
        end
        apply(0, 0, 2'd0, 0, 0, 0, $urandom);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule